// File: doc/BRIEF.md
# Multi-Context Configuration Plane Controller

This block keeps the configuration words of a small reconfigurable datapath in four planes. One plane is live and its words drive the array through a wide output. The other planes can be refilled from a configuration stream while the live plane keeps running. Moving the array onto another plane costs a single clock edge, so reloading adds no dead time.

Each plane holds one function, named by a tag, and a valid flag. A fill begins with a load request that names a plane and a tag. That marks the plane busy. Words then arrive on the stream, and the word flagged as final completes the fill. An execute request carries a tag. If some plane already holds that function, the array moves to that plane without a reload. If the tag is still being filled, the request stalls. If no plane holds it, the request is reported as a miss.

The configuration stream and the execute request both use valid/ready. A transfer happens on a rising edge where both are high. The stream's ready drops only in cycles where a load request is present. The execute ready drops only while the requested tag is held by a plane that is still filling. Ready never depends on the next stimulus, and the source must hold its payload until the transfer.

Top module: `mcp_ctrl`

## Requirements
- R1: After reset, every plane reads not valid and not busy, plane 0 is live, the live words read all zeros, and all three error pulses are low.
- R2: A load request to a plane that is not live makes that plane busy and not valid, and stores the new tag, from the next edge on. A load request to the live plane, or to the plane that an accepted switch selects in the same cycle, changes nothing and raises `load_err` for one cycle after the edge.
- R3: An accepted stream word for a busy plane is written at `cfg_addr` of `cfg_plane`. When the accepted word also has `cfg_last`=1, the plane becomes valid and not busy after the edge.
- R4: An accepted stream word for the live plane, or for a plane that is not busy, is dropped. `cfg_err` is high for one cycle after the edge, and no stored word changes.
- R5: An execute request whose tag matches a valid plane sees `exec_ready`=1 in the same cycle. After the edge that plane is live and `act_words` shows its words, with word k at bits [k*16 +: 16]. The plane stays valid and no fill is needed.
- R6: An execute request whose tag matches only busy planes sees `exec_ready`=0, and the live plane does not change while it waits.
- R7: If the final word of a plane's fill is accepted in the same cycle as a waiting execute request for that plane's tag, `exec_ready` is 1 in that cycle. After the edge that plane is live, and its words include the final word.
- R8: An execute request whose tag matches no valid or busy plane is accepted (`exec_ready`=1). `exec_miss` is high for one cycle after the edge, and the live plane is unchanged.
- R9: When several valid planes carry the requested tag, the lowest-numbered one becomes live.
- R10: `cfg_ready` is 0 in every cycle where `load_req` is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Stream word present |
| cfg_ready | output | 1 | Stream word can be taken |
| cfg_plane | input | 2 | Destination plane of the word |
| cfg_addr | input | 3 | Word index within the plane |
| cfg_data | input | 16 | Configuration word |
| cfg_last | input | 1 | Final word of the fill |
| cfg_err | output | 1 | Pulse: a word was dropped |
| load_req | input | 1 | Start a fill |
| load_plane | input | 2 | Plane to fill |
| load_tag | input | 4 | Function tag for the fill |
| load_err | output | 1 | Pulse: the load request was refused |
| exec_valid | input | 1 | Execute request present |
| exec_ready | output | 1 | Execute request taken |
| exec_tag | input | 4 | Function wanted |
| exec_miss | output | 1 | Pulse: no plane holds the tag |
| plane_valid | output | 4 | Per-plane complete flag |
| plane_busy | output | 4 | Per-plane filling flag |
| active_plane | output | 2 | Live plane index |
| act_words | output | 128 | Live plane's words |

## Verification
`cfg_ready` and `exec_ready` are combinational, so the bench reads them 1 ns after driving inputs on the falling edge, in the same cycle. Every other result comes from a register: plane flags, the live index, the live words, and the three error pulses. Each of these appears after exactly one rising edge, so the bench checks it on the next falling edge, where a one-cycle pulse is still visible. The stall test holds the request for several cycles and checks the live plane at each falling edge. In the completion test, the final word and the waiting request share one edge, and the bench checks for the switch on the falling edge that follows.

// File: rtl/cfgplane_pkg.sv
package cfgplane_pkg;
  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_HIT  = 2'd1,
    LK_WAIT = 2'd2
  } lookup_e;
endpackage

// File: rtl/cfgplane_store.sv
module cfgplane_store #(
  parameter int NP = 4,
  parameter int NW = 8,
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NP)-1:0]    wplane,
  input  logic [$clog2(NW)-1:0]    waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NP)-1:0]    rplane,
  output logic [NW-1:0][DW-1:0]    rwords
);
  logic [NP-1:0][NW-1:0][DW-1:0] bank;

  for (genvar gp = 0; gp < NP; gp++) begin : g_plane
    logic [NW-1:0][DW-1:0] words_q;
    always_ff @(posedge clk) begin
      if (!rst_n) words_q <= '0;
      else if (we && wplane == gp) words_q[waddr] <= wdata;
    end
    assign bank[gp] = words_q;
  end

  assign rwords = bank[rplane];

  // R4: the live plane is never written
  a_r4_no_live_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wplane != rplane));
endmodule

// File: rtl/cfgplane_track.sv
module cfgplane_track #(
  parameter int NP = 4,
  parameter int TW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_ok,
  input  logic [$clog2(NP)-1:0]    load_plane,
  input  logic [TW-1:0]            load_tag,
  input  logic                     done,
  input  logic [$clog2(NP)-1:0]    done_plane,
  input  logic [$clog2(NP)-1:0]    active,
  output logic [NP-1:0]            valid,
  output logic [NP-1:0]            busy,
  output logic [NP-1:0][TW-1:0]    tags
);
  for (genvar gp = 0; gp < NP; gp++) begin : g_slot
    logic          v_q, b_q;
    logic [TW-1:0] t_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        b_q <= 1'b0;
        t_q <= '0;
      end else if (load_ok && load_plane == gp) begin
        v_q <= 1'b0;
        b_q <= 1'b1;
        t_q <= load_tag;
      end else if (done && done_plane == gp) begin
        v_q <= 1'b1;
        b_q <= 1'b0;
      end
    end
    assign valid[gp] = v_q;
    assign busy[gp]  = b_q;
    assign tags[gp]  = t_q;
  end

  // R2: the live plane is never in the middle of a fill
  a_r2_live_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[active]);
  // R3: a completed fill leaves the plane valid and idle
  a_r3_done_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_ok) |=> (valid[$past(done_plane)] && !busy[$past(done_plane)]));
  // R1: valid and busy are exclusive per plane
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (valid & busy) == '0);
endmodule

// File: rtl/cfgplane_select.sv
module cfgplane_select
  import cfgplane_pkg::*;
#(
  parameter int NP = 4,
  parameter int TW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NP-1:0]            valid,
  input  logic [NP-1:0]            busy,
  input  logic [NP-1:0][TW-1:0]    tags,
  input  logic                     done,
  input  logic [$clog2(NP)-1:0]    done_plane,
  input  logic                     exec_valid,
  input  logic [TW-1:0]            exec_tag,
  output logic                     exec_ready,
  output logic                     sw_fire,
  output logic [$clog2(NP)-1:0]    sw_target,
  output logic [$clog2(NP)-1:0]    active_q,
  output logic                     miss_q
);
  localparam int PW = $clog2(NP);

  logic [NP-1:0] tag_eq, hit_valid, hit_done, hit_busy;
  lookup_e       kind;
  logic [PW-1:0] idx;

  for (genvar gp = 0; gp < NP; gp++) begin : g_cmp
    assign tag_eq[gp]    = (tags[gp] == exec_tag);
    assign hit_valid[gp] = tag_eq[gp] && valid[gp];
    assign hit_done[gp]  = tag_eq[gp] && busy[gp] && done && (done_plane == gp);
    assign hit_busy[gp]  = tag_eq[gp] && busy[gp];
  end

  always_comb begin
    kind = LK_MISS;
    idx  = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (hit_busy[i]) begin
        kind = LK_WAIT;
        idx  = PW'(i);
      end
    end
    for (int i = NP - 1; i >= 0; i--) begin
      if (hit_done[i]) begin
        kind = LK_HIT;
        idx  = PW'(i);
      end
    end
    if (hit_valid != '0) begin
      for (int i = NP - 1; i >= 0; i--) begin
        if (hit_valid[i]) idx = PW'(i);
      end
      kind = LK_HIT;
    end
  end

  assign exec_ready = (kind != LK_WAIT);
  assign sw_fire    = exec_valid && (kind == LK_HIT);
  assign sw_target  = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      miss_q   <= 1'b0;
    end else begin
      if (sw_fire) active_q <= idx;
      miss_q <= exec_valid && (kind == LK_MISS);
    end
  end

  // R6: a stalled request leaves the live plane alone
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_ready) |=> $stable(active_q));
  // R5: a switch always lands on a complete plane
  a_r5_switch_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> valid[active_q]);
  // R8: a miss is flagged and does not move the live plane
  a_r8_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_ready && !sw_fire) |=> (miss_q && $stable(active_q)));
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl #(
  parameter int NP = 4,
  parameter int NW = 8,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_valid,
  output logic                      cfg_ready,
  input  logic [$clog2(NP)-1:0]     cfg_plane,
  input  logic [$clog2(NW)-1:0]     cfg_addr,
  input  logic [DW-1:0]             cfg_data,
  input  logic                      cfg_last,
  output logic                      cfg_err,
  input  logic                      load_req,
  input  logic [$clog2(NP)-1:0]     load_plane,
  input  logic [TW-1:0]             load_tag,
  output logic                      load_err,
  input  logic                      exec_valid,
  output logic                      exec_ready,
  input  logic [TW-1:0]             exec_tag,
  output logic                      exec_miss,
  output logic [NP-1:0]             plane_valid,
  output logic [NP-1:0]             plane_busy,
  output logic [$clog2(NP)-1:0]     active_plane,
  output logic [NW*DW-1:0]          act_words
);
  localparam int PW = $clog2(NP);

  logic                    cfg_fire, wr_ok, done, load_ok;
  logic                    sw_fire;
  logic [PW-1:0]           sw_target, active;
  logic [NP-1:0][TW-1:0]   tags;
  logic [NW-1:0][DW-1:0]   rwords;
  logic                    cfg_err_q, load_err_q;

  assign cfg_ready = !load_req;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign wr_ok     = cfg_fire && plane_busy[cfg_plane] && (cfg_plane != active);
  assign done      = wr_ok && cfg_last;
  assign load_ok   = load_req && (load_plane != active)
                     && !(sw_fire && sw_target == load_plane);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err_q  <= 1'b0;
      load_err_q <= 1'b0;
    end else begin
      cfg_err_q  <= cfg_fire && !wr_ok;
      load_err_q <= load_req && !load_ok;
    end
  end

  cfgplane_store #(.NP(NP), .NW(NW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .wplane(cfg_plane),
    .waddr(cfg_addr), .wdata(cfg_data), .rplane(active), .rwords(rwords)
  );

  cfgplane_track #(.NP(NP), .TW(TW)) u_track (
    .clk(clk), .rst_n(rst_n), .load_ok(load_ok), .load_plane(load_plane),
    .load_tag(load_tag), .done(done), .done_plane(cfg_plane), .active(active),
    .valid(plane_valid), .busy(plane_busy), .tags(tags)
  );

  cfgplane_select #(.NP(NP), .TW(TW)) u_select (
    .clk(clk), .rst_n(rst_n), .valid(plane_valid), .busy(plane_busy),
    .tags(tags), .done(done), .done_plane(cfg_plane),
    .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_ready(exec_ready),
    .sw_fire(sw_fire), .sw_target(sw_target), .active_q(active),
    .miss_q(exec_miss)
  );

  assign active_plane = active;
  assign act_words    = rwords;
  assign cfg_err      = cfg_err_q;
  assign load_err     = load_err_q;

  // R10: a fill request holds off the stream for that cycle
  a_r10_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !$past(wr_ok));
endmodule

// File: tb/test_mcp_ctrl.sv
module test_mcp_ctrl;
  localparam int NP = 4, NW = 8, DW = 16, TW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, cfg_last = 0, load_req = 0, exec_valid = 0;
  logic [1:0] cfg_plane = 0, load_plane = 0;
  logic [2:0] cfg_addr = 0;
  logic [DW-1:0] cfg_data = 0;
  logic [TW-1:0] load_tag = 0, exec_tag = 0;
  logic cfg_ready, cfg_err, load_err, exec_ready, exec_miss;
  logic [NP-1:0] plane_valid, plane_busy;
  logic [1:0] active_plane;
  logic [NW*DW-1:0] act_words;

  always #5 clk = ~clk;

  mcp_ctrl i_mcp_ctrl (.*);

  int vecs = 0, fails = 0;
  logic [DW-1:0] mem_e [NP][NW];
  logic [NP-1:0] val_e = 0, busy_e = 0;
  logic [TW-1:0] tag_e [NP];
  int act_e = 0;

  task automatic chk(string req, logic [NW*DW-1:0] act, logic [NW*DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(string req);
    logic [NW*DW-1:0] w;
    for (int k = 0; k < NW; k++) w[k*DW +: DW] = mem_e[act_e][k];
    chk({req, " valid"}, plane_valid, val_e);
    chk({req, " busy"}, plane_busy, busy_e);
    chk({req, " live"}, active_plane, act_e);
    chk({req, " words"}, act_words, w);
  endtask

  function automatic logic [DW-1:0] wv(int p, int a, int g);
    return DW'(p * 4096 + a * 256 + g * 17 + a * 3 + 1);
  endfunction

  // kind: 0 miss, 1 hit, 2 wait
  task automatic lookup(logic [TW-1:0] t, output int kind, output int idx);
    kind = 0; idx = 0;
    for (int i = NP - 1; i >= 0; i--) if (busy_e[i] && tag_e[i] == t) begin kind = 2; idx = i; end
    for (int i = NP - 1; i >= 0; i--) if (val_e[i] && tag_e[i] == t) begin kind = 1; idx = i; end
  endtask

  task automatic do_load(int p, int t);
    bit rej;
    load_req = 1; load_plane = 2'(p); load_tag = TW'(t);
    #1 chk("R10 cfg_ready", cfg_ready, 0);
    tick;
    load_req = 0;
    rej = (p == act_e);
    if (!rej) begin busy_e[p] = 1; val_e[p] = 0; tag_e[p] = TW'(t); end
    chk("R2 load_err", load_err, rej);
    check_state("R2");
    #1 chk("R10 cfg_ready idle", cfg_ready, 1);
  endtask

  task automatic do_write(int p, int a, logic [DW-1:0] d, bit last);
    bit ok;
    cfg_valid = 1; cfg_plane = 2'(p); cfg_addr = 3'(a); cfg_data = d; cfg_last = last;
    ok = busy_e[p] && (p != act_e);
    tick;
    cfg_valid = 0; cfg_last = 0;
    if (ok) begin
      mem_e[p][a] = d;
      if (last) begin busy_e[p] = 0; val_e[p] = 1; end
    end
    chk(ok ? "R3 cfg_err" : "R4 cfg_err", cfg_err, !ok);
    check_state(ok ? "R3" : "R4");
  endtask

  task automatic fill(int p, int g);
    for (int a = 0; a < NW; a++) do_write(p, a, wv(p, a, g), a == NW - 1);
  endtask

  task automatic do_exec(int t, string req);
    int kind, idx;
    exec_valid = 1; exec_tag = TW'(t);
    lookup(TW'(t), kind, idx);
    #1 chk({req, " exec_ready"}, exec_ready, kind != 2);
    tick;
    exec_valid = 0;
    if (kind == 1) act_e = idx;
    chk({req, " exec_miss"}, exec_miss, kind == 0);
    check_state(req);
  endtask

  initial begin
    #2_000_000;
    fails++; vecs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      tag_e[p] = 0;
      for (int a = 0; a < NW; a++) mem_e[p][a] = 0;
    end
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick;
    check_state("R1");
    chk("R1 errs", {cfg_err, load_err, exec_miss}, 0);

    // sweep: each generation refills every non-live plane, then moves on
    for (int g = 0; g < 4; g++) begin
      for (int p = 0; p < NP; p++) do_load(p, g * 4 + p);
      for (int p = 0; p < NP; p++) if (p != act_e) fill(p, g);
      do_write(act_e, 0, 16'hDEAD, 1);            // R4 live plane
      do_write((act_e + 2) % NP, 1, 16'hBEEF, 0);  // R4 idle plane
      if (g == 0) do_exec(9, "R8");
      do_exec(tag_e[(act_e + 1) % NP], "R5");
    end

    // R6 stall then R7 same-cycle completion on plane 1, tag 5
    do_load(1, 5);
    for (int a = 0; a < NW - 1; a++) do_write(1, a, wv(1, a, 7), 0);
    exec_valid = 1; exec_tag = 5;
    for (int n = 0; n < 3; n++) begin
      #1 chk("R6 exec_ready", exec_ready, 0);
      tick;
      check_state("R6");
    end
    cfg_valid = 1; cfg_plane = 1; cfg_addr = 3'(NW - 1); cfg_data = wv(1, NW - 1, 7); cfg_last = 1;
    #1 chk("R7 exec_ready", exec_ready, 1);
    tick;
    cfg_valid = 0; cfg_last = 0; exec_valid = 0;
    mem_e[1][NW - 1] = wv(1, NW - 1, 7); busy_e[1] = 0; val_e[1] = 1; act_e = 1;
    check_state("R7");

    // R9 duplicate tags on planes 2 and 3
    do_load(3, 3); fill(3, 9);
    do_load(2, 3); fill(2, 8);
    do_exec(3, "R9");
    chk("R9 live index", active_plane, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule